// File: doc/BRIEF.md
# Noise-Filtered Serial Command Slave

This block receives command and data bytes over a chip-select framed, three-wire synchronous serial link. It also returns read-back bytes on a serial output that can be switched off. The clock and data lines can be noisy, so neither is used directly. Both are sampled on a tick at half the system clock rate. A new level is taken only once two successive samples agree, so a pulse of one sample period or less never reaches the shifter. Chip select is registered once.

A frame opens when chip select falls. The serial clock idles high. The output bit is moved on each accepted falling edge, and the input bit is captured on each accepted rising edge, most significant bit first. The frame runs through three named states. IDLE holds while chip select is high, and goes to CMD when chip select falls. CMD goes to DISP when a completed byte carries the display-data opcode in its top three bits. Any state returns to IDLE when chip select rises. In CMD every completed byte is presented with the command strobe. In DISP every completed byte is presented with the data strobe. The first two bytes sent out in a frame are filler. From the third byte on, each outgoing byte is taken from a parallel input port at the start of that byte.

Top module: `nfser_slave`

## Requirements
- R1: A sample tick occurs every 2 system clocks. A level on the serial clock or data input is accepted only when it is read the same on two successive ticks. A pulse on either line that lasts 1 or 2 system clocks has no effect on received bytes.
- R2: Each accepted rising edge of the serial clock shifts the accepted data level in, MSB first. After 8 rises the byte appears on `rx_byte`, together with a one-clock strobe.
- R3: Every byte completed while no display-data command has been seen in the frame is flagged with `cmd_stb`. `cmd_stb` and `dat_stb` are never high together.
- R4: A command byte whose bits [7:5] equal 3'b111 moves the frame to DISP. `disp_mode` is high from the cycle of that byte's strobe. Every later byte in the frame is flagged with `dat_stb`, whatever its value.
- R5: A rising chip select returns the block to IDLE. This clears `disp_mode`, the bit count and the byte count. A partly shifted byte produces no strobe, and the next frame starts clean.
- R6: `sout_oe` is low during reset and while the registered chip select is high. It is high while the frame is open. It drops one clock after chip select rises.
- R7: `sout` carries 8'hFF for the first two bytes of a frame. For each later byte it carries the value of `rd_byte` taken at that byte's first accepted falling edge, MSB first. `sout` changes only after an accepted falling edge, and it settles within 8 system clocks (4 ticks) of the raw edge.
- R8: A serial clock high phase of 4 system clocks (2 ticks) and a low phase of 8 clocks are recognised as full bit periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles high |
| sin | input | 1 | Serial data in |
| rd_byte | input | 8 | Read-back byte for the third and later outgoing bytes |
| sout | output | 1 | Serial data out |
| sout_oe | output | 1 | Output enable for `sout` (low means high impedance) |
| rx_byte | output | 8 | Last completed received byte |
| cmd_stb | output | 1 | One-clock strobe: `rx_byte` is a command |
| dat_stb | output | 1 | One-clock strobe: `rx_byte` is display data |
| disp_mode | output | 1 | Frame is in the display-data state |

## Verification
The assertions check several properties on every cycle. The accepted levels change only on a tick. The two strobes are exclusive. A data strobe only follows an established display state. An idle cycle leaves the bit count and display flag cleared. `sout` holds between accepted falling edges. The enable drops after chip select rises. Only the bench scenarios can show the behaviour seen from outside. These cover glitch rejection measured through the received bytes, the MSB-first values, the command and data classification across a frame, the filler and read-back sequence on `sout`, abort recovery, and minimum-width clock phases.

// File: rtl/nfser_pkg.sv
package nfser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_DISP = 2'd2
    } frame_st_t;
endpackage

// File: rtl/nfser_tick.sv
module nfser_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/nfser_glitch.sv
module nfser_glitch #(
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic raw,
    output logic lvl
);
    logic sync_q;
    logic samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= RST_LVL;
            samp_q <= RST_LVL;
            lvl    <= RST_LVL;
        end else begin
            sync_q <= raw;
            if (tick) begin
                samp_q <= sync_q;
                if (sync_q == samp_q) lvl <= sync_q;
            end
        end
    end

    // R1: the accepted level moves only on a sample tick
    p_lvl_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl != $past(lvl)) |-> $past(tick));
endmodule

// File: rtl/nfser_rx.sv
module nfser_rx
    import nfser_pkg::*;
#(
    parameter int W = 8,
    parameter int SKIP = 2,
    parameter int OPC_W = 3,
    parameter logic [OPC_W-1:0] OPC = 3'b111
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         rise,
    input  logic         sin_lvl,
    output logic [W-1:0] rx_byte,
    output logic         cmd_stb,
    output logic         dat_stb,
    output logic         disp_mode,
    output logic         bit_zero,
    output logic         skip_done
);
    localparam int BW = $clog2(W);
    localparam int SW = (SKIP > 0) ? $clog2(SKIP + 1) : 1;

    frame_st_t     state_q, state_d;
    logic [BW-1:0] bit_q;
    logic [SW-1:0] skip_q;
    logic [W-1:0]  sh_q;
    logic [W-1:0]  new_byte;
    logic          byte_done;

    assign new_byte  = {sh_q[W-2:0], sin_lvl};
    assign byte_done = cs_act && rise && (bit_q == BW'(W - 1));
    assign bit_zero  = (bit_q == '0);
    assign skip_done = (skip_q == SW'(SKIP));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_act) state_d = ST_CMD;
            ST_CMD: begin
                if (!cs_act) state_d = ST_IDLE;
                else if (byte_done && new_byte[W-1 -: OPC_W] == OPC) state_d = ST_DISP;
            end
            ST_DISP: if (!cs_act) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        disp_mode = (state_q == ST_DISP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            skip_q  <= '0;
            sh_q    <= '0;
            rx_byte <= '0;
            cmd_stb <= 1'b0;
            dat_stb <= 1'b0;
        end else begin
            cmd_stb <= byte_done && (state_q != ST_DISP);
            dat_stb <= byte_done && (state_q == ST_DISP);
            if (!cs_act) begin
                bit_q  <= '0;
                skip_q <= '0;
            end else if (rise) begin
                sh_q  <= new_byte;
                bit_q <= byte_done ? '0 : bit_q + 1'b1;
                if (byte_done) begin
                    rx_byte <= new_byte;
                    if (!skip_done) skip_q <= skip_q + 1'b1;
                end
            end
        end
    end

    // R3: a byte is either a command or data, never both
    p_stb_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_stb, dat_stb}));
    // R4: data strobes only follow an established display state
    p_data_after_disp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dat_stb |-> $past(disp_mode));
    // R5: an idle frame leaves no bit count and no display state
    p_idle_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> (bit_zero && !disp_mode));
endmodule

// File: rtl/nfser_tx.sv
module nfser_tx #(
    parameter int W = 8,
    parameter logic [W-1:0] FILL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_act,
    input  logic         fall,
    input  logic         bit_zero,
    input  logic         skip_done,
    input  logic [W-1:0] rd_byte,
    output logic         sout,
    output logic         sout_oe
);
    logic [W-1:0] tx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tx_q <= FILL;
        else if (!cs_act) tx_q <= FILL;
        else if (fall) begin
            if (bit_zero) tx_q <= skip_done ? rd_byte : FILL;
            else          tx_q <= {tx_q[W-2:0], 1'b0};
        end
    end

    assign sout    = tx_q[W-1];
    assign sout_oe = cs_act;

    // R7: the output bit holds between accepted falling edges
    p_sout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$past(fall)) |-> $stable(sout));
endmodule

// File: rtl/nfser_slave.sv
module nfser_slave #(
    parameter int W = 8,
    parameter int DIV = 2,
    parameter int SKIP = 2,
    parameter int OPC_W = 3,
    parameter logic [OPC_W-1:0] OPC = 3'b111,
    parameter logic [W-1:0] FILL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sin,
    input  logic [W-1:0] rd_byte,
    output logic         sout,
    output logic         sout_oe,
    output logic [W-1:0] rx_byte,
    output logic         cmd_stb,
    output logic         dat_stb,
    output logic         disp_mode
);
    logic tick, sclk_lvl, sin_lvl, sclk_d, cs_q;
    logic cs_act, rise, fall, bit_zero, skip_done;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_d <= 1'b1;
        end else begin
            cs_q   <= cs_n;
            sclk_d <= sclk_lvl;
        end
    end

    assign cs_act = !cs_q;
    assign rise   = sclk_lvl && !sclk_d;
    assign fall   = !sclk_lvl && sclk_d;

    nfser_tick #(.DIV(DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

    nfser_glitch #(.RST_LVL(1'b1)) u_flt_sclk (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(sclk), .lvl(sclk_lvl));

    nfser_glitch #(.RST_LVL(1'b0)) u_flt_sin (
        .clk(clk), .rst_n(rst_n), .tick(tick), .raw(sin), .lvl(sin_lvl));

    nfser_rx #(.W(W), .SKIP(SKIP), .OPC_W(OPC_W), .OPC(OPC)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rise(rise), .sin_lvl(sin_lvl),
        .rx_byte(rx_byte), .cmd_stb(cmd_stb), .dat_stb(dat_stb),
        .disp_mode(disp_mode), .bit_zero(bit_zero), .skip_done(skip_done));

    nfser_tx #(.W(W), .FILL(FILL)) u_tx (
        .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .fall(fall),
        .bit_zero(bit_zero), .skip_done(skip_done), .rd_byte(rd_byte),
        .sout(sout), .sout_oe(sout_oe));

    // R6: output enable drops one clock after chip select rises
    p_oe_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> !sout_oe);
endmodule

// File: tb/nfser_slave_bench.sv
module nfser_slave_bench;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic       rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b1, sin = 1'b0;
    logic [7:0] rd_byte = 8'h00;
    logic       sout, sout_oe, cmd_stb, dat_stb, disp_mode;
    logic [7:0] rx_byte;

    int n_run = 0, n_fail = 0, rc = 0, glen = 1;
    bit done = 1'b0;
    logic [7:0] rec_b [0:1023];
    bit         rec_d [0:1023];
    logic [7:0] fb [0:7];
    logic [7:0] rdv [0:7];

    nfser_slave u_nfser_slave (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sin(sin),
        .rd_byte(rd_byte), .sout(sout), .sout_oe(sout_oe), .rx_byte(rx_byte),
        .cmd_stb(cmd_stb), .dat_stb(dat_stb), .disp_mode(disp_mode));

    always @(negedge clk) begin
        if (cmd_stb || dat_stb) begin
            if (rc < 1024) begin
                rec_b[rc] = rx_byte;
                rec_d[rc] = dat_stb;
            end
            rc++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_out(input int k, input logic [7:0] rdk);
        return (k < 2) ? 8'hFF : rdk;
    endfunction

    task automatic send_bits(input logic [7:0] b, input int nb, input int hi, input int lo,
                             input bit gl, output logic [7:0] got, output bit oe_ok);
        got = 8'h00;
        oe_ok = 1'b1;
        for (int i = 7; i > 7 - nb; i--) begin
            sclk = 1'b0;
            wclk(1);
            sin = b[i];
            if (gl && i == 4) begin
                wclk(2);
                sclk = 1'b1; wclk(glen); sclk = 1'b0;
                wclk(4);
                sin = ~b[i]; wclk(1); sin = b[i];
                wclk(4);
            end
            wclk(lo - 1);
            got[i] = sout;
            if (!sout_oe) oe_ok = 1'b0;
            sclk = 1'b1;
            wclk(hi);
        end
    endtask

    task automatic run_frame(input int nb, input int hi, input int lo, input bit gl, input int abort_bits);
        int base;
        logic [7:0] g;
        bit oe_ok, dexp;
        bit kind [0:7];
        base = rc;
        dexp = 1'b0;
        cs_n = 1'b0;
        wclk(4);
        chk(sout_oe == 1'b1, "R6 enable in frame", 32'(sout_oe), 32'd1);
        for (int k = 0; k < nb; k++) begin
            rd_byte = rdv[k];
            send_bits(fb[k], 8, hi, lo, gl, g, oe_ok);
            chk(g == exp_out(k, rdv[k]), "R7 sout byte", 32'(g), 32'(exp_out(k, rdv[k])));
            chk(oe_ok, "R6 enable per bit", 32'(oe_ok), 32'd1);
            kind[k] = dexp;
            if (!dexp && fb[k][7:5] == 3'b111) dexp = 1'b1;
            wclk(4);
            chk(disp_mode == dexp, "R4 display flag", 32'(disp_mode), 32'(dexp));
        end
        if (abort_bits > 0) send_bits(8'hA5, abort_bits, hi, lo, 1'b0, g, oe_ok);
        wclk(6);
        cs_n = 1'b1;
        wclk(3);
        chk(sout_oe == 1'b0, "R6 enable off after frame", 32'(sout_oe), 32'd0);
        chk(disp_mode == 1'b0, "R5 display cleared", 32'(disp_mode), 32'd0);
        chk(rc - base == nb, "R5 strobe count (no partial byte)", 32'(rc - base), 32'(nb));
        for (int k = 0; k < nb; k++) begin
            chk(rec_b[base+k] == fb[k], "R2 received byte", 32'(rec_b[base+k]), 32'(fb[k]));
            chk(rec_d[base+k] == kind[k], "R3 command/data kind", 32'(rec_d[base+k]), 32'(kind[k]));
        end
        wclk(6);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int nb, hi, lo, ab;
        bit gl;
        void'($urandom(32'd4242));
        cs_n = 1'b0;
        wclk(4);
        chk(sout_oe == 1'b0, "R6 enable off in reset", 32'(sout_oe), 32'd0);
        chk(disp_mode == 1'b0, "R5 reset display flag", 32'(disp_mode), 32'd0);
        chk({cmd_stb, dat_stb} == 2'b00, "R3 reset strobes", 32'({cmd_stb, dat_stb}), 32'd0);
        cs_n = 1'b1;
        wclk(2);
        rst_n = 1'b1;
        wclk(6);

        // commands only, then display command mid-frame, data that looks like commands
        fb[0] = 8'h9A; fb[1] = 8'hC3; fb[2] = 8'hE5; fb[3] = 8'hE0; fb[4] = 8'h3C;
        for (int k = 0; k < 8; k++) rdv[k] = 8'(8'h5A + 8'(k * 37));
        run_frame(5, 6, 9, 1'b0, 0);

        // R8: shortest clock phases
        fb[0] = 8'hE1; fb[1] = 8'h81; fb[2] = 8'h7E;
        run_frame(3, 4, 8, 1'b0, 0);

        // R1: one-clock and two-clock glitches on both lines
        glen = 1;
        fb[0] = 8'h00; fb[1] = 8'hFF; fb[2] = 8'hA5;
        run_frame(3, 5, 8, 1'b1, 0);
        glen = 2;
        fb[0] = 8'hF0; fb[1] = 8'h0F; fb[2] = 8'h96;
        run_frame(3, 5, 9, 1'b1, 0);

        // R5: abort mid-byte, next frame must start clean
        fb[0] = 8'hE7; fb[1] = 8'h12;
        run_frame(2, 6, 8, 1'b0, 3);
        fb[0] = 8'h44; fb[1] = 8'hE2;
        run_frame(2, 6, 8, 1'b0, 0);

        for (int f = 0; f < 16; f++) begin
            nb = 1 + int'($urandom % 5);
            for (int k = 0; k < 8; k++) begin
                fb[k]  = 8'($urandom);
                rdv[k] = 8'($urandom);
            end
            if ($urandom % 2 == 0) fb[0][7:5] = 3'b111;
            hi = 4 + int'($urandom % 5);
            lo = 8 + int'($urandom % 4);
            gl = ($urandom % 3 == 0);
            glen = 1 + int'($urandom % 2);
            ab = ($urandom % 4 == 0) ? 1 + int'($urandom % 6) : 0;
            run_frame(nb, hi, lo, gl, ab);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule